// File: doc/BRIEF.md
# Stack register rename scoreboard

This block is the issue controller of a stack-organised floating-point unit with eight registers. Instructions name stack positions (ST0 to ST7). A rename table translates each position to a physical register. A pending bit on each physical register records a result that is still in flight. Each cycle at most one instruction arrives: add, multiply, divide or exchange. The block either issues it or holds it back through a valid/ready handshake. Data values are never touched; each result is an opaque tag that comes back on a retire port when the fixed latency of its operation has elapsed.

An exchange only swaps two entries of the rename table and never occupies an execution slot. Code that names the top of stack in every instruction can therefore still keep the pipelined adder and multiplier busy on every cycle. A busy flag tells the integer side whether any operation is still in flight. A wait request is answered as soon as that flag is low.

Top module: `fpu_rename_sb`

## Requirements
- R1: After reset, stack position i maps to physical register i, no register is pending, `busy` is low and `in_ready` is high.
- R2: An add or multiply accepted at clock edge n is reported at edge n+3. `cmp_valid` is high in the cycle before that edge, with `cmp_preg` the physical register that the destination mapped to at issue and `cmp_tag` the accepted `in_tag`. A divide is reported the same way 19 edges after issue.
- R3: Independent adds and multiplies are accepted on consecutive cycles with no gap.
- R4: An arithmetic instruction is held (`in_ready` low) while the physical register of its source or its destination is pending. It may be accepted in the cycle in which that register is being reported on the retire port.
- R5: An exchange (`in_op` = 3) swaps the mappings of ST0 and ST(`in_src`). It is always ready and creates no retire entry.
- R6: A divide is not accepted while an earlier divide has more than its final cycle left. Within the default parameters a second divide may follow the first no sooner than 19 edges later.
- R7: An add or multiply is held when an operation already in flight would be reported in the same cycle as the new one, so that at most one result retires per cycle.
- R8: `busy` is high exactly while some physical register is pending. `wait_done` is high when `wait_req` is high and `busy` is low.
- R9: An exchange involving a pending register still issues at once. Later hazards follow the physical register to its new stack position.
- R10: With `in_valid` low, nothing changes: no register becomes pending and the rename table stays as it was.
- R11: Opcode encoding on `in_op`: 0 add, 1 multiply, 2 divide, 3 exchange. Arithmetic writes ST(`in_dst`) and reads ST(`in_dst`) and ST(`in_src`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_op | input | 2 | Opcode (0 add, 1 mul, 2 div, 3 exchange) |
| in_dst | input | 3 | Destination stack position |
| in_src | input | 3 | Source stack position (exchange partner of ST0) |
| in_tag | input | 8 | Opaque result tag |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| wait_req | input | 1 | Integer side asks to wait for the unit |
| wait_done | output | 1 | Wait request satisfied |
| busy | output | 1 | Some operation still in flight |
| cmp_valid | output | 1 | A result retires this cycle |
| cmp_preg | output | 3 | Physical register of the retiring result |
| cmp_tag | output | 8 | Tag of the retiring result |

## Verification
A run of four adds that all read ST0 and write separate positions shows whether independent work truly overlaps. A chain in which each add reads the previous result shows whether the hazard check holds for exactly three cycles and releases on the retire cycle. Exchanges before and after arithmetic to ST0 tell a swapped mapping apart from an identity mapping, including an exchange of a still-pending register. Back-to-back divides, and an add timed to land on a divide's retire cycle, separate the divide-occupancy rule from the retire-collision rule. A long random mix is compared cycle by cycle against a queue-based model.

// File: rtl/fpu_rs_pkg.sv
// Shared definitions for the stack register rename scoreboard.
// Assumes a two-bit opcode field on the issue port.
package fpu_rs_pkg;

    typedef enum logic [1:0] {
        FOP_ADD = 2'd0,
        FOP_MUL = 2'd1,
        FOP_DIV = 2'd2,
        FOP_XCH = 2'd3
    } fop_e;

endpackage

// File: rtl/fpu_rename_map.sv
// Rename table: maps each stack position to a physical register.
// Two read ports are combinational. One swap port exchanges the
// entries of position 0 and position swap_idx on the clock edge.
// Assumes NREG is a power of two.
module fpu_rename_map #(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    output logic [IW-1:0] rd_a_phys,
    input  logic [IW-1:0] rd_b_idx,
    output logic [IW-1:0] rd_b_phys,
    input  logic          swap_en,
    input  logic [IW-1:0] swap_idx
);

    logic [IW-1:0] map_q [NREG];

    // Identity mapping on reset; swap of two names on an exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                map_q[i] <= IW'(i);
            end
        end else if (swap_en) begin
            map_q[0]        <= map_q[swap_idx];
            map_q[swap_idx] <= map_q[0];
        end
    end

    // Combinational lookups for the issuing instruction.
    always_comb begin
        rd_a_phys = map_q[rd_a_idx];
        rd_b_phys = map_q[rd_b_idx];
    end

endmodule

// File: rtl/fpu_pend_sb.sv
// Pending-bit scoreboard, one bit per physical register.
// A set marks a register written by an issuing instruction; a clear
// removes the mark when the result retires. The effective view already
// excludes the register retiring this cycle, so a dependant can issue
// in that cycle. Set wins over clear on the same register.
module fpu_pend_sb #(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] pend_eff,
    output logic            any_pend
);

    logic [NREG-1:0] pend_q;

    // Update pending bits from issue and retire events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (set_en && set_idx == IW'(i)) begin
                    pend_q[i] <= 1'b1;
                end else if (clr_en && clr_idx == IW'(i)) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    // Hazard view with the retiring register bypassed.
    always_comb begin
        pend_eff = pend_q;
        if (clr_en) begin
            pend_eff[clr_idx] = 1'b0;
        end
    end

    // Unit busy whenever any result is outstanding.
    always_comb begin
        any_pend = |pend_q;
    end

endmodule

// File: rtl/fpu_retire_line.sv
// Retire line: a shift line of DEPTH slots in which slot r holds the
// operation reported r cycles from now (slot 1 retires this cycle).
// An issue writes its entry straight into the slot equal to its
// latency. Occupancy is exported for collision checks, and a flag
// shows a divide that still has more than its final cycle to run.
module fpu_retire_line #(
    parameter int DEPTH = 19,
    parameter int IW    = 3,
    parameter int TW    = 8,
    parameter int SW    = $clog2(DEPTH + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [SW-1:0]   push_slot,
    input  logic [IW-1:0]   push_preg,
    input  logic [TW-1:0]   push_tag,
    input  logic            push_div,
    output logic [DEPTH:1]  occ,
    output logic            div_live,
    output logic            head_vld,
    output logic [IW-1:0]   head_preg,
    output logic [TW-1:0]   head_tag
);

    typedef struct packed {
        logic          v;
        logic          dv;
        logic [IW-1:0] p;
        logic [TW-1:0] t;
    } slot_t;

    slot_t slot_q [1:DEPTH+1];

    // Slot past the end is permanently empty and feeds the last slot.
    assign slot_q[DEPTH+1] = '0;

    for (genvar r = 1; r <= DEPTH; r++) begin : g_slot
        // Load a new entry at its latency slot, else advance one place.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[r] <= '0;
            end else if (push_en && push_slot == SW'(r)) begin
                slot_q[r] <= '{v: 1'b1, dv: push_div, p: push_preg, t: push_tag};
            end else begin
                slot_q[r] <= slot_q[r+1];
            end
        end

        // Occupancy bit of this slot.
        assign occ[r] = slot_q[r].v;
    end

    // A divide beyond slot 1 still holds the divider.
    always_comb begin
        div_live = 1'b0;
        for (int r = 2; r <= DEPTH; r++) begin
            if (slot_q[r].v && slot_q[r].dv) begin
                div_live = 1'b1;
            end
        end
    end

    // Retiring entry.
    always_comb begin
        head_vld  = slot_q[1].v;
        head_preg = slot_q[1].p;
        head_tag  = slot_q[1].t;
    end

endmodule

// File: rtl/fpu_rename_sb.sv
// Issue control for a stack-organised floating-point unit.
// Looks up the physical registers of the offered instruction, checks
// pending bits, retire-slot collisions and divider occupancy, and
// accepts at most one instruction per cycle. Exchanges only swap names.
// Assumes latencies of at least 1 and a divide latency of at least 2.
module fpu_rename_sb #(
    parameter int NREG    = 8,
    parameter int TW      = 8,
    parameter int ADD_LAT = 3,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_op,
    input  logic [$clog2(NREG)-1:0]  in_dst,
    input  logic [$clog2(NREG)-1:0]  in_src,
    input  logic [TW-1:0]            in_tag,
    output logic                     in_ready,
    input  logic                     wait_req,
    output logic                     wait_done,
    output logic                     busy,
    output logic                     cmp_valid,
    output logic [$clog2(NREG)-1:0]  cmp_preg,
    output logic [TW-1:0]            cmp_tag
);
    import fpu_rs_pkg::*;

    localparam int IW    = $clog2(NREG);
    localparam int AM    = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int DEPTH = (AM > DIV_LAT) ? AM : DIV_LAT;
    localparam int SW    = $clog2(DEPTH + 2);

    fop_e            op;
    logic [IW-1:0]   dst_p;
    logic [IW-1:0]   src_p;
    logic [NREG-1:0] pend_eff;
    logic            any_pend;
    logic [DEPTH:1]  occ;
    logic            div_live;
    logic            head_vld;
    logic [IW-1:0]   head_preg;
    logic [TW-1:0]   head_tag;
    logic [SW-1:0]   lat;
    logic            is_xch;
    logic            is_div;
    logic            hazard;
    logic            collide;
    logic            take;
    logic            arith_take;

    // Decode the opcode and select the operation latency.
    always_comb begin
        op     = fop_e'(in_op);
        is_xch = (op == FOP_XCH);
        is_div = (op == FOP_DIV);
        case (op)
            FOP_ADD: lat = SW'(ADD_LAT);
            FOP_MUL: lat = SW'(MUL_LAT);
            FOP_DIV: lat = SW'(DIV_LAT);
            default: lat = '0;
        endcase
    end

    fpu_rename_map #(.NREG(NREG), .IW(IW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (in_dst),
        .rd_a_phys (dst_p),
        .rd_b_idx  (in_src),
        .rd_b_phys (src_p),
        .swap_en   (take && is_xch),
        .swap_idx  (in_src)
    );

    fpu_pend_sb #(.NREG(NREG), .IW(IW)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (arith_take),
        .set_idx  (dst_p),
        .clr_en   (head_vld),
        .clr_idx  (head_preg),
        .pend_eff (pend_eff),
        .any_pend (any_pend)
    );

    fpu_retire_line #(.DEPTH(DEPTH), .IW(IW), .TW(TW), .SW(SW)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (arith_take),
        .push_slot (lat),
        .push_preg (dst_p),
        .push_tag  (in_tag),
        .push_div  (is_div),
        .occ       (occ),
        .div_live  (div_live),
        .head_vld  (head_vld),
        .head_preg (head_preg),
        .head_tag  (head_tag)
    );

    // Data hazard on either operand's physical register.
    always_comb begin
        hazard = pend_eff[src_p] | pend_eff[dst_p];
    end

    // Would the new result land in a slot already claimed one step later?
    always_comb begin
        collide = 1'b0;
        for (int r = 1; r <= DEPTH; r++) begin
            if (occ[r] && SW'(r) == lat + SW'(1)) begin
                collide = 1'b1;
            end
        end
    end

    // Ready decision per opcode class.
    always_comb begin
        if (is_xch) begin
            in_ready = 1'b1;
        end else if (is_div) begin
            in_ready = !hazard && !collide && !div_live;
        end else begin
            in_ready = !hazard && !collide;
        end
    end

    // Handshake and outputs.
    always_comb begin
        take       = in_valid && in_ready;
        arith_take = take && !is_xch;
        busy       = any_pend;
        wait_done  = wait_req && !any_pend;
        cmp_valid  = head_vld;
        cmp_preg   = head_preg;
        cmp_tag    = head_tag;
    end

endmodule

// File: rtl/fpu_rename_sb_chk.sv
// Property checker for the rename scoreboard, attached with bind.
module fpu_rename_sb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_op,
    input logic       in_ready,
    input logic       wait_req,
    input logic       wait_done,
    input logic       busy,
    input logic       cmp_valid
);

    // R8
    cmp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> busy);

    // R8
    wait_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && busy) |-> !wait_done);

    // R5
    xch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd3) |-> in_ready);

    // R6
    div_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'd2) |=> !(in_valid && in_ready && in_op == 2'd2));

    // R10
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !$rose(busy));

    // R5
    xch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd3) |=> !$rose(busy));

endmodule

bind fpu_rename_sb fpu_rename_sb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_ready  (in_ready),
    .wait_req  (wait_req),
    .wait_done (wait_done),
    .busy      (busy),
    .cmp_valid (cmp_valid)
);

// File: tb/fpu_rename_sb_test.sv
// Bench: queue-based reference model compared on every clock, plus
// directed scenarios for each requirement.
module fpu_rename_sb_test;

    localparam int L_ADD = 3;
    localparam int L_MUL = 3;
    localparam int L_DIV = 19;
    localparam logic [1:0] OP_ADD = 2'd0;
    localparam logic [1:0] OP_MUL = 2'd1;
    localparam logic [1:0] OP_DIV = 2'd2;
    localparam logic [1:0] OP_XCH = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = 2'd0;
    logic [2:0] in_dst = 3'd0;
    logic [2:0] in_src = 3'd0;
    logic [7:0] in_tag = 8'd0;
    logic       in_ready;
    logic       wait_req = 1'b0;
    logic       wait_done;
    logic       busy;
    logic       cmp_valid;
    logic [2:0] cmp_preg;
    logic [7:0] cmp_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpu_rename_sb uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src(in_src), .in_tag(in_tag), .in_ready(in_ready),
        .wait_req(wait_req), .wait_done(wait_done), .busy(busy),
        .cmp_valid(cmp_valid), .cmp_preg(cmp_preg), .cmp_tag(cmp_tag)
    );

    typedef struct {
        int when;
        int preg;
        int tag;
        bit dv;
    } ent_t;

    int   m_map [8];
    bit   m_pend [8];
    ent_t m_q [$];
    int   m_e;

    bit last_rdy;
    bit last_cv;
    int last_cp;
    int last_ct;

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] op);
        if (op == OP_DIV) return L_DIV;
        if (op == OP_MUL) return L_MUL;
        return L_ADD;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_map[i]  = i;
            m_pend[i] = 1'b0;
        end
        m_q.delete();
        m_e = 0;
    endtask

    task automatic model_expect(output bit rdy, output bit cv, output int cp, output int ct);
        int sp;
        int dp;
        int l;
        bit haz;
        bit coll;
        bit dbusy;
        cv = 1'b0; cp = 0; ct = 0;
        foreach (m_q[k]) begin
            if (m_q[k].when == m_e) begin
                cv = 1'b1; cp = m_q[k].preg; ct = m_q[k].tag;
            end
        end
        sp = m_map[in_src];
        dp = m_map[in_dst];
        l  = lat_of(in_op);
        haz = (m_pend[sp] && !(cv && cp == sp)) || (m_pend[dp] && !(cv && cp == dp));
        coll = 1'b0;
        dbusy = 1'b0;
        foreach (m_q[k]) begin
            if (m_q[k].when == m_e + l) coll = 1'b1;
            if (m_q[k].dv && m_q[k].when > m_e) dbusy = 1'b1;
        end
        if (in_op == OP_XCH) rdy = 1'b1;
        else if (in_op == OP_DIV) rdy = !haz && !coll && !dbusy;
        else rdy = !haz && !coll;
    endtask

    task automatic model_update(input bit rdy, input bit cv, input int cp);
        int tmp;
        if (cv) begin
            m_pend[cp] = 1'b0;
            for (int k = m_q.size() - 1; k >= 0; k--) begin
                if (m_q[k].when == m_e) m_q.delete(k);
            end
        end
        if (in_valid && rdy) begin
            if (in_op == OP_XCH) begin
                tmp = m_map[0];
                m_map[0] = m_map[in_src];
                m_map[in_src] = tmp;
            end else begin
                m_pend[m_map[in_dst]] = 1'b1;
                m_q.push_back('{when: m_e + lat_of(in_op), preg: m_map[in_dst],
                                tag: int'(in_tag), dv: (in_op == OP_DIV)});
            end
        end
        m_e++;
    endtask

    // Drive one cycle, compare with the model, advance one edge.
    task automatic go(input bit v, input logic [1:0] op, input int d, input int s,
                      input int t, input bit w);
        bit er;
        bit ecv;
        int ecp;
        int ect;
        bit eb;
        in_valid = v; in_op = op; in_dst = 3'(d); in_src = 3'(s);
        in_tag = 8'(t); wait_req = w;
        #1;
        model_expect(er, ecv, ecp, ect);
        eb = 1'b0;
        for (int i = 0; i < 8; i++) if (m_pend[i]) eb = 1'b1;
        chk(int'(in_ready), int'(er), "R4 in_ready vs model");
        chk(int'(cmp_valid), int'(ecv), "R2 cmp_valid vs model");
        if (ecv) begin
            chk(int'(cmp_preg), ecp, "R2 cmp_preg vs model");
            chk(int'(cmp_tag), ect, "R2 cmp_tag vs model");
        end
        chk(int'(busy), int'(eb), "R8 busy vs model");
        chk(int'(wait_done), int'(w && !eb), "R8 wait_done vs model");
        last_rdy = in_ready; last_cv = cmp_valid;
        last_cp = int'(cmp_preg); last_ct = int'(cmp_tag);
        @(posedge clk);
        model_update(er, ecv, ecp);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go(1'b0, OP_ADD, 0, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        go(1'b0, OP_ADD, 0, 0, 0, 1'b0);
        chk(int'(busy), 0, "R1 busy after reset");
        chk(int'(last_rdy), 1, "R1 ready after reset");

        // R1/R2: identity map, add latency of three edges
        go(1'b1, OP_ADD, 5, 5, 8'h11, 1'b0);
        idle(2);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b0);
        chk(int'(last_cv), 1, "R2 add retires third cycle");
        chk(last_cp, 5, "R1 identity mapping of ST5");
        chk(last_ct, 8'h11, "R2 tag returned");

        // R3: four independent adds plus a multiply, back to back
        for (int i = 1; i <= 4; i++) begin
            go(1'b1, OP_ADD, i, 0, i, 1'b0);
            chk(int'(last_rdy), 1, "R3 independent add accepted");
        end
        go(1'b1, OP_MUL, 5, 0, 5, 1'b0);
        chk(int'(last_rdy), 1, "R3 independent mul accepted");
        idle(4);

        // R4: dependent add waits until producer retire cycle
        go(1'b1, OP_ADD, 1, 0, 8'h21, 1'b0);
        go(1'b1, OP_ADD, 2, 1, 8'h22, 1'b0);
        chk(int'(last_rdy), 0, "R4 dependant held 1");
        go(1'b1, OP_ADD, 2, 1, 8'h22, 1'b0);
        chk(int'(last_rdy), 0, "R4 dependant held 2");
        go(1'b1, OP_ADD, 2, 1, 8'h22, 1'b0);
        chk(int'(last_rdy), 1, "R4 dependant released on retire cycle");
        idle(4);

        // R5: exchange ST0 with ST3, then add to ST0 lands on physical 3
        go(1'b1, OP_XCH, 0, 3, 0, 1'b0);
        chk(int'(last_rdy), 1, "R5 exchange ready");
        go(1'b1, OP_ADD, 0, 0, 8'h55, 1'b0);
        idle(2);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b0);
        chk(last_cp, 3, "R5 ST0 renamed to physical 3");

        // R6: second divide held for 18 cycles
        go(1'b1, OP_DIV, 1, 2, 8'h61, 1'b0);
        for (int k = 1; k <= 18; k++) begin
            go(1'b1, OP_DIV, 4, 5, 8'h62, 1'b0);
            chk(int'(last_rdy), 0, "R6 second divide held");
        end
        go(1'b1, OP_DIV, 4, 5, 8'h62, 1'b0);
        chk(int'(last_rdy), 1, "R6 second divide on retire cycle");
        chk(int'(last_cv), 1, "R6 divide latency 19");
        chk(last_ct, 8'h61, "R6 divide tag");
        idle(20);

        // R7: add landing on divide retire cycle is held one cycle
        go(1'b1, OP_DIV, 1, 1, 8'h71, 1'b0);
        idle(15);
        go(1'b1, OP_ADD, 2, 3, 8'h72, 1'b0);
        chk(int'(last_rdy), 0, "R7 retire collision held");
        go(1'b1, OP_ADD, 2, 3, 8'h72, 1'b0);
        chk(int'(last_rdy), 1, "R7 accepted one cycle later");
        idle(22);

        // R9: exchange of a pending register issues; hazard follows it
        go(1'b1, OP_ADD, 0, 0, 8'h91, 1'b0);
        go(1'b1, OP_XCH, 0, 2, 0, 1'b0);
        chk(int'(last_rdy), 1, "R9 exchange of pending issues");
        go(1'b1, OP_ADD, 2, 1, 8'h92, 1'b0);
        chk(int'(last_rdy), 0, "R9 hazard follows renamed register");
        idle(6);

        // R8: wait handshake
        go(1'b1, OP_MUL, 6, 7, 8'h81, 1'b0);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b1);
        chk(int'(wait_done), 0, "R8 wait pending while busy");
        chk(int'(busy), 1, "R8 busy during multiply");
        go(1'b0, OP_ADD, 0, 0, 0, 1'b1);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b1);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b1);
        chk(int'(busy), 0, "R8 busy low after retire");
        chk(int'(wait_done), 1, "R8 wait satisfied");

        // R10: invalid offers change nothing
        go(1'b0, OP_XCH, 0, 5, 0, 1'b0);
        go(1'b0, OP_DIV, 3, 3, 0, 1'b0);
        go(1'b0, OP_ADD, 4, 4, 0, 1'b0);
        chk(int'(busy), 0, "R10 no pending from invalid offers");
        chk(int'(last_cv), 0, "R10 no retire from invalid offers");
        go(1'b1, OP_ADD, 5, 5, 8'hA1, 1'b0);
        idle(2);
        go(1'b0, OP_ADD, 0, 0, 0, 1'b0);
        chk(last_cp, 5, "R10 ST5 mapping unchanged");

        // R11: random mix against the model
        for (int i = 0; i < 600; i++) begin
            go(($urandom % 4) != 0, 2'($urandom % 4), int'($urandom % 8),
               int'($urandom % 8), int'($urandom % 256), 1'(($urandom % 2)));
        end
        idle(25);
        chk(int'(busy), 0, "R11 drained after random mix");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule